// File: doc/BRIEF.md
# Vectored Interrupt Priority Core

This block keeps the pending, in-service and trigger-type state for every interrupt vector a processor core can take. Each vector is an index into three bit arrays. Vector numbers also carry priority: the upper four bits form a priority class, and a higher number wins.

From the arrays and a software-programmed task priority, the block derives the processor's current priority. It then decides whether the highest pending request may interrupt the core. The interrupt line is a registered level, recomputed every cycle.

When the core acknowledges, the block hands back one of three results:
- the winning vector, which moves from pending to in-service;
- a spurious code, when the request is masked by priority;
- a "nothing" code, when there is no request or the block is disabled.

When the core signals end of interrupt, the highest in-service vector is retired. If that vector was level-triggered and broadcast suppression is off, a one-cycle broadcast pulse carries the vector, so that upstream sources can re-evaluate their lines.

Top module: `irq_prio_core`

## Requirements
- R1: After reset all three arrays are empty, and `irq_out`, `ack_done` and `eoi_bcast` are low. With the in-service array empty, `proc_pri` equals `task_pri`.
- R2: A cycle with `set_valid` high sets the pending bit of `set_vector`. It also records the trigger type of that vector: `set_level` 1 means level, 0 means edge.
- R3: The selected pending and in-service vectors are always the highest-numbered set bit of their array.
- R4: `proc_pri` equals `task_pri` when `task_pri[7:4]` is at least the class (bits 7:4) of the top in-service vector. Otherwise it equals that class followed by four zero bits. An empty in-service array counts as vector 0.
- R5: After each clock edge, `irq_out` is 1 exactly when, before that edge, all three of these held:
  - `sw_enable` was 1;
  - a request was pending;
  - either `proc_pri` was 0 or the top request's class exceeded `proc_pri[7:4]`.
- R6: When `ack_strobe` is high and a request is deliverable, the next cycle shows `ack_done`=1, `ack_kind`=1 and `ack_vec` = the top request. That vector's pending bit is cleared and its in-service bit is set.
- R7: When `ack_strobe` is high and a request exists but is masked by priority, the next cycle shows `ack_kind`=2 with `ack_vec` = `spur_vec`, and no array changes.
- R8: When `ack_strobe` is high and either `sw_enable` is 0 or no request is pending, the next cycle shows `ack_kind`=0 and `ack_vec`=0, and no array changes.
- R9: An `eoi_strobe` clears the top in-service bit. If that vector's trigger type is level and `eoi_suppress` is 0, the next cycle shows `eoi_bcast`=1 with `eoi_vec` = that vector.
- R10: An `eoi_strobe` with an empty in-service array changes nothing and emits no broadcast.
- R11: When a set and an acknowledge fall in the same cycle, the set wins: if both name the same vector, its pending bit stays set. When an acknowledge and an end of interrupt fall in the same cycle, the retirement is applied first and the acknowledge's in-service set afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| set_valid | input | 1 | Raise a request this cycle |
| set_vector | input | 8 | Vector to raise |
| set_level | input | 1 | Trigger type of the raised vector: 1 level, 0 edge |
| task_pri | input | 8 | Task priority value |
| spur_vec | input | 8 | Vector returned for a masked acknowledge |
| sw_enable | input | 1 | Software enable; 0 blocks all delivery |
| eoi_suppress | input | 1 | 1 suppresses the end-of-interrupt broadcast |
| ack_strobe | input | 1 | Core acknowledges an interrupt |
| eoi_strobe | input | 1 | Core signals end of interrupt |
| irq_out | output | 1 | Registered interrupt request to the core |
| proc_pri | output | 8 | Current processor priority |
| ack_done | output | 1 | Acknowledge result valid (one cycle) |
| ack_kind | output | 2 | 0 none, 1 vector, 2 spurious |
| ack_vec | output | 8 | Acknowledge result vector |
| eoi_bcast | output | 1 | End-of-interrupt broadcast pulse |
| eoi_vec | output | 8 | Vector carried by the broadcast |

## Verification
Several functions can share a single cycle:
- a request can be raised in the same cycle the core acknowledges, including for the very vector being acknowledged;
- an acknowledge can coincide with an end of interrupt.

Directed steps provoke both collisions on purpose, including a re-raise of a vector that is pending and winning. A long random phase then drives set, acknowledge and end of interrupt independently, so the collisions recur under many priority states.

A behavioural model in the bench applies the retirement, then the acknowledge's move, then the set. The block's results, broadcasts and surviving pending state are compared with that model on every clock.

// File: rtl/irq_prio_core.sv
module irq_prio_core #(
  parameter int NVEC = 256
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      set_valid,
  input  logic [$clog2(NVEC)-1:0]   set_vector,
  input  logic                      set_level,
  input  logic [$clog2(NVEC)-1:0]   task_pri,
  input  logic [$clog2(NVEC)-1:0]   spur_vec,
  input  logic                      sw_enable,
  input  logic                      eoi_suppress,
  input  logic                      ack_strobe,
  input  logic                      eoi_strobe,
  output logic                      irq_out,
  output logic [$clog2(NVEC)-1:0]   proc_pri,
  output logic                      ack_done,
  output logic [1:0]                ack_kind,
  output logic [$clog2(NVEC)-1:0]   ack_vec,
  output logic                      eoi_bcast,
  output logic [$clog2(NVEC)-1:0]   eoi_vec
);
  localparam int VW = $clog2(NVEC);
  localparam int CW = 4;
  localparam logic [1:0] KIND_NONE = 2'd0;
  localparam logic [1:0] KIND_VEC  = 2'd1;
  localparam logic [1:0] KIND_SPUR = 2'd2;

  logic [NVEC-1:0] req_q, svc_q, lvl_q;
  logic [NVEC-1:0] req_n, svc_n, lvl_n;

  function automatic logic [VW:0] top_of(input logic [NVEC-1:0] a);
    logic [VW:0] r;
    r = '0;
    for (int i = 0; i < NVEC; i++)
      if (a[i]) r = {1'b1, VW'(i)};
    return r;
  endfunction

  wire [VW:0]    req_top = top_of(req_q);
  wire [VW:0]    svc_top = top_of(svc_q);
  wire [VW-1:0]  req_v   = req_top[VW-1:0];
  wire [VW-1:0]  svc_v   = svc_top[VW-1:0];
  wire [CW-1:0]  svc_cls = svc_v[VW-1 -: CW];

  assign proc_pri = (task_pri[VW-1 -: CW] >= svc_cls) ? task_pri
                                                      : {svc_cls, {(VW-CW){1'b0}}};

  wire has_req = sw_enable && req_top[VW];
  wire masked  = (proc_pri != '0) && (req_v[VW-1 -: CW] <= proc_pri[VW-1 -: CW]);
  wire deliver = has_req && !masked;
  wire take    = ack_strobe && deliver;
  wire retire  = eoi_strobe && svc_top[VW];

  always_comb begin
    req_n = req_q;
    svc_n = svc_q;
    lvl_n = lvl_q;
    if (take)   req_n[req_v] = 1'b0;
    if (retire) svc_n[svc_v] = 1'b0;
    if (take)   svc_n[req_v] = 1'b1;
    if (set_valid) begin
      req_n[set_vector] = 1'b1;
      lvl_n[set_vector] = set_level;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q     <= '0;
      svc_q     <= '0;
      lvl_q     <= '0;
      irq_out   <= 1'b0;
      ack_done  <= 1'b0;
      ack_kind  <= KIND_NONE;
      ack_vec   <= '0;
      eoi_bcast <= 1'b0;
      eoi_vec   <= '0;
    end else begin
      req_q    <= req_n;
      svc_q    <= svc_n;
      lvl_q    <= lvl_n;
      irq_out  <= deliver;
      ack_done <= ack_strobe;
      if (ack_strobe) begin
        if (deliver) begin
          ack_kind <= KIND_VEC;
          ack_vec  <= req_v;
        end else if (has_req) begin
          ack_kind <= KIND_SPUR;
          ack_vec  <= spur_vec;
        end else begin
          ack_kind <= KIND_NONE;
          ack_vec  <= '0;
        end
      end
      eoi_bcast <= retire && lvl_q[svc_v] && !eoi_suppress;
      eoi_vec   <= retire ? svc_v : '0;
    end
  end

  // R5: the line can only be raised while software enable was on
  a_r5_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> $past(sw_enable));

  // R6: a delivered vector is in service when it is reported
  a_r6_ack_in_service: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_done && ack_kind == KIND_VEC) |-> svc_q[ack_vec]);

  // R7: the spurious result carries the programmed spurious vector
  a_r7_spur_value: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_done && ack_kind == KIND_SPUR) |-> ack_vec == $past(spur_vec));

  // R9: a broadcast needs an end-of-interrupt strobe with suppression off
  a_r9_bcast_cause: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_bcast |-> ($past(eoi_strobe) && !$past(eoi_suppress)));

  // R8: with enable off an acknowledge never reports a vector
  a_r8_disabled_none: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_strobe && !sw_enable) |=> ack_kind != KIND_VEC);

  // R10: nothing is retired from an empty in-service array
  a_r10_empty_eoi: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_strobe && svc_q == '0) |=> !eoi_bcast);
endmodule

// File: tb/irq_prio_core_test.sv
`timescale 1ns/1ps
module irq_prio_core_test;
  logic clk = 0, rst_n = 0;
  logic set_valid = 0, set_level = 0, sw_enable = 0, eoi_suppress = 0;
  logic ack_strobe = 0, eoi_strobe = 0;
  logic [7:0] set_vector = 0, task_pri = 0, spur_vec = 8'h3F;
  logic irq_out, ack_done, eoi_bcast;
  logic [1:0] ack_kind;
  logic [7:0] proc_pri, ack_vec, eoi_vec;

  irq_prio_core uut (.clk, .rst_n, .set_valid, .set_vector, .set_level, .task_pri,
    .spur_vec, .sw_enable, .eoi_suppress, .ack_strobe, .eoi_strobe, .irq_out,
    .proc_pri, .ack_done, .ack_kind, .ack_vec, .eoi_bcast, .eoi_vec);

  always #4 clk = ~clk;

  int checks = 0, fails = 0;
  bit finished = 0;
  string cur = "R1";

  bit [255:0] m_req, m_svc, m_lvl;
  bit e_irq, e_ackd, e_bc;
  int e_kind, e_vec, e_bv;

  function automatic int hi(bit [255:0] a);
    for (int i = 255; i >= 0; i--) if (a[i]) return i;
    return -1;
  endfunction

  function automatic int ppr_of(bit [255:0] s, int tp);
    int iv = hi(s);
    if (iv < 0) iv = 0;
    if ((tp >> 4) >= (iv >> 4)) return tp;
    return (iv >> 4) << 4;
  endfunction

  always @(posedge clk) begin : model
    int rt, st, pp, kd;
    if (!rst_n) begin
      m_req = '0; m_svc = '0; m_lvl = '0;
      e_irq = 0; e_ackd = 0; e_bc = 0; e_kind = 0; e_vec = 0; e_bv = 0;
    end else begin
      rt = hi(m_req); st = hi(m_svc); pp = ppr_of(m_svc, task_pri);
      if (!sw_enable || rt < 0) kd = 0;
      else if (pp != 0 && (rt >> 4) <= (pp >> 4)) kd = 2;
      else kd = 1;
      e_irq = (kd == 1);
      e_ackd = ack_strobe;
      if (ack_strobe) begin
        e_kind = kd;
        e_vec = (kd == 1) ? rt : (kd == 2) ? int'(spur_vec) : 0;
      end
      e_bc = 0; e_bv = 0;
      if (eoi_strobe && st >= 0) begin
        e_bc = m_lvl[st] && !eoi_suppress;
        e_bv = st;
        m_svc[st] = 0;
      end
      if (ack_strobe && kd == 1) begin
        m_req[rt] = 0;
        m_svc[rt] = 1;
      end
      if (set_valid) begin
        m_req[set_vector] = 1;
        m_lvl[set_vector] = set_level;
      end
    end
  end

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s (%s): actual %0h expected %0h", req, what, cur, act, exp);
    end
  endtask

  always @(negedge clk) begin
    #2;
    if (rst_n && !finished) begin
      check("R5", "irq_out", irq_out, e_irq);
      check("R4", "proc_pri", proc_pri, ppr_of(m_svc, task_pri));
      check("R9", "eoi_bcast", eoi_bcast, e_bc);
      if (e_bc) check("R9", "eoi_vec", eoi_vec, e_bv);
      check("R6", "ack_done", ack_done, e_ackd);
      if (e_ackd) begin
        check(e_kind == 1 ? "R6" : e_kind == 2 ? "R7" : "R8", "ack_kind", ack_kind, e_kind);
        check(e_kind == 1 ? "R6" : e_kind == 2 ? "R7" : "R8", "ack_vec", ack_vec, e_vec);
      end
    end
  end

  task automatic drive(bit sv, int vec, bit lv, bit ak, bit eo);
    @(negedge clk);
    set_valid = sv; set_vector = vec[7:0]; set_level = lv;
    ack_strobe = ak; eoi_strobe = eo;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) drive(0, 0, 0, 0, 0);
  endtask

  task automatic summary;
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #1600000;
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  initial begin
    task_pri = 8'h00;
    repeat (3) @(negedge clk);
    #2;
    // R1: reset state
    check("R1", "irq_out", irq_out, 0);
    check("R1", "ack_done", ack_done, 0);
    check("R1", "eoi_bcast", eoi_bcast, 0);
    check("R1", "proc_pri", proc_pri, 0);
    @(negedge clk); rst_n = 1; sw_enable = 1;

    cur = "R2";
    drive(1, 8'h41, 1, 0, 0);
    drive(1, 8'h30, 0, 0, 0);
    idle(2);
    cur = "R3";
    drive(0, 0, 0, 1, 0);
    idle(1);
    cur = "R9";
    drive(0, 0, 0, 0, 1);
    drive(0, 0, 0, 1, 0);
    drive(0, 0, 0, 0, 1);
    idle(1);

    cur = "R7";
    task_pri = 8'h50;
    drive(1, 8'h55, 1, 0, 0);
    drive(0, 0, 0, 1, 0);
    idle(1);
    task_pri = 8'h20;
    cur = "R6";
    drive(0, 0, 0, 1, 0);
    drive(1, 8'h52, 0, 0, 0);
    cur = "R4";
    drive(0, 0, 0, 1, 0);
    idle(1);

    cur = "R10";
    drive(0, 0, 0, 0, 1);
    drive(0, 0, 0, 0, 1);
    drive(0, 0, 0, 0, 1);
    idle(1);

    cur = "R8";
    sw_enable = 0;
    drive(0, 0, 0, 1, 0);
    idle(1);
    sw_enable = 1;
    drive(0, 0, 0, 1, 0);
    idle(1);

    cur = "R11";
    task_pri = 0;
    drive(1, 8'h90, 1, 0, 0);
    drive(1, 8'h90, 1, 1, 0);
    drive(0, 0, 0, 1, 1);
    drive(0, 0, 0, 1, 1);
    idle(2);

    cur = "random";
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 15) == 0) task_pri = 8'($urandom_range(0, 255));
      if ($urandom_range(0, 31) == 0) eoi_suppress = ~eoi_suppress;
      sw_enable = ($urandom_range(0, 19) != 0);
      spur_vec = 8'($urandom_range(0, 255));
      drive($urandom_range(0, 9) < 3, $urandom_range(0, 255), $urandom_range(0, 1),
            $urandom_range(0, 4) == 0, $urandom_range(0, 4) == 0);
    end
    idle(3);
    summary();
  end
endmodule